// File: doc/BRIEF.md
# Serial EEPROM Target on a Two-Wire Bus

This block is a two-wire (I2C) target that makes an internal byte array look like a serial EEPROM to a bus host. It runs on a fast system clock. It oversamples the bus clock and data lines, finds start, repeated start and stop conditions, and walks each transfer one bit at a time. It answers only to its own 7-bit device address. It accepts a two-byte word address and serves byte writes, page writes, current-address reads, random reads and sequential reads.

Written bytes collect in a page buffer. Nothing reaches the array until the host ends the transfer with a stop. After the stop, a counter of system clocks models the internal programming time. While that counter runs, the target stays silent on the bus, so the host can poll it until it answers again. A write-protect input blocks programming, but the target still acknowledges the address phases. The data line is driven only as an open-drain low enable.

Top module: `i2c_eeprom_target`

## Requirements
- R1: The target acknowledges a device byte only when bits 7..1 equal 1010 followed by chip_sel_i[2:0]. Bit 0 selects the direction: 0 means write and 1 means read. The acknowledge is SDA held low during the ninth clock. Any other device byte receives no acknowledge.
- R2: After a write device byte, the target acknowledges two word-address bytes, high byte first. Only the low ADDR_W bits of the 16-bit word address are used, and the upper bits are don't-care. A data byte written to an address is returned later by a random read of that address. A random read is a write of the address, then a repeated start, then a read device byte.
- R3: In a write transfer, each data byte is acknowledged. After each byte, only the low PAGE_BITS bits of the address advance, and the page bits stay fixed. A transfer that passes the page end wraps to the page start and overwrites the bytes already buffered there.
- R4: Buffered bytes are programmed only when the transfer ends with a stop. A write transfer that is cut off by a repeated start leaves the array unchanged and starts no write cycle.
- R5: After a stop that ends a write transfer with data, the target acknowledges no device byte for WR_CYCLE_CLKS system clocks. After that time it acknowledges its write address again.
- R6: While wp_i is high, the target acknowledges the device byte and both word-address bytes. It refuses the first data byte, leaves the array unchanged and starts no write cycle.
- R7: The address counter holds the last accessed address plus one. A current-address read returns the byte at that address. The counter wraps from 2**ADDR_W-1 to 0.
- R8: In a read, the target sends another byte while the host acknowledges. The full address increments between bytes and wraps to 0. After a host no-acknowledge, the target releases SDA.
- R9: sda_oe_o is 0 after reset and changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| chip_sel_i | input | 3 | Low three bits of the device address |
| wp_i | input | 1 | Write protect; high blocks programming |
| sda_oe_o | output | 1 | High pulls the data line low |

## Verification
The assertions assume a well-formed host. The host moves SDA only while SCL is low, except when it makes a start or stop. It never makes a start or stop while the target is pulling SDA low. The bench host keeps every data change inside the low half of the bit period, a quarter-bit after the falling edge. It issues start and stop only after the target has released the line. It also holds wp_i and chip_sel_i steady across each transfer, so a protection change never falls in the middle of an address phase.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_AHI,
      ST_ALO,
      ST_WDAT,
      ST_RDAT
   } ee_state_t;
endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_q,
   output logic sda_q,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_p, sda_p;
   logic              scl_d, sda_d;

   if (STAGES < 1) begin : g_bad_stages
      $error("STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
         end else begin
            scl_p <= scl_i;
            sda_p <= sda_i;
         end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
         end else begin
            scl_p <= {scl_p[STAGES-2:0], scl_i};
            sda_p <= {sda_p[STAGES-2:0], sda_i};
         end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_q;
         sda_d <= sda_q;
      end

   assign scl_q     = scl_p[STAGES-1];
   assign sda_q     = sda_p[STAGES-1];
   assign scl_rise  = scl_q && !scl_d;
   assign scl_fall  = !scl_q && scl_d;
   assign start_det = scl_q && scl_d && sda_d && !sda_q;
   assign stop_det  = scl_q && scl_d && !sda_d && sda_q;
endmodule

// File: rtl/i2c_ee_store.sv
module i2c_ee_store #(
   parameter int ADDR_W        = 10,
   parameter int PAGE_BITS     = 6,
   parameter int WR_CYCLE_CLKS = 5000
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        buf_we,
   input  logic [PAGE_BITS-1:0]        buf_idx,
   input  logic [7:0]                  buf_data,
   input  logic [ADDR_W-PAGE_BITS-1:0] page_sel,
   input  logic                        buf_clr,
   input  logic                        commit,
   input  logic [ADDR_W-1:0]           rd_addr,
   output logic [7:0]                  rd_data,
   output logic                        busy
);
   localparam int PAGE  = 1 << PAGE_BITS;
   localparam int DEPTH = 1 << ADDR_W;
   localparam int CNT_W = $clog2(WR_CYCLE_CLKS + 1);

   if (WR_CYCLE_CLKS < PAGE) begin : g_bad_cycle
      $error("WR_CYCLE_CLKS must cover one clock per page byte");
   end

   logic [7:0]                  mem  [DEPTH];
   logic [7:0]                  pbuf [PAGE];
   logic [PAGE-1:0]             valid;
   logic [ADDR_W-PAGE_BITS-1:0] page_q;
   logic [CNT_W-1:0]            cnt;
   logic [PAGE_BITS-1:0]        cidx;

   assign cidx    = cnt[PAGE_BITS-1:0];
   assign rd_data = mem[rd_addr];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         busy   <= 1'b0;
         cnt    <= '0;
         valid  <= '0;
         page_q <= '0;
      end else begin
         if (busy) begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(WR_CYCLE_CLKS - 1)) begin
               busy  <= 1'b0;
               valid <= '0;
            end
         end else if (commit && |valid) begin
            busy <= 1'b1;
            cnt  <= '0;
         end else if (buf_clr) begin
            valid <= '0;
         end
         if (buf_we && !busy) begin
            valid[buf_idx] <= 1'b1;
            page_q         <= page_sel;
         end
      end

   always_ff @(posedge clk)
      if (buf_we && !busy) pbuf[buf_idx] <= buf_data;

   always_ff @(posedge clk)
      if (busy && cnt < CNT_W'(PAGE) && valid[cidx])
         mem[{page_q, cidx}] <= pbuf[cidx];
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
   parameter int         ADDR_W        = 10,
   parameter int         PAGE_BITS     = 6,
   parameter int         WR_CYCLE_CLKS = 5000,
   parameter int         SYNC_STAGES   = 2,
   parameter logic [3:0] DEV_TYPE      = 4'b1010
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [2:0] chip_sel_i,
   input  logic       wp_i,
   output logic       sda_oe_o
);
   import i2c_ee_pkg::*;

   if (ADDR_W < 9 || ADDR_W > 16 || PAGE_BITS >= ADDR_W) begin : g_bad_geom
      $error("ADDR_W must be 9..16 and exceed PAGE_BITS");
   end

   logic scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
   logic busy, commit, buf_we;
   logic [7:0] rd_data;

   ee_state_t            st;
   logic [3:0]           bitcnt;
   logic [7:0]           sh;
   logic [6:0]           tx;
   logic [ADDR_W-9:0]    ahi;
   logic [ADDR_W-1:0]    addr_ptr, addr_inc, page_inc;
   logic [PAGE_BITS-1:0] off_inc;
   logic                 in_ack, rd_dir, more, wr_pending, byte_done;

   i2c_ee_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   assign byte_done = scl_fall && !in_ack && bitcnt == 4'd8;
   assign buf_we    = byte_done && st == ST_WDAT && !wp_i;
   assign commit    = stop_det && wr_pending;
   assign off_inc   = addr_ptr[PAGE_BITS-1:0] + 1'b1;
   assign page_inc  = {addr_ptr[ADDR_W-1:PAGE_BITS], off_inc};
   assign addr_inc  = addr_ptr + 1'b1;

   i2c_ee_store #(
      .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .WR_CYCLE_CLKS(WR_CYCLE_CLKS)
   ) store_i (
      .clk(clk), .rst_n(rst_n), .buf_we(buf_we),
      .buf_idx(addr_ptr[PAGE_BITS-1:0]), .buf_data(sh),
      .page_sel(addr_ptr[ADDR_W-1:PAGE_BITS]), .buf_clr(start_det),
      .commit(commit), .rd_addr(addr_ptr), .rd_data(rd_data), .busy(busy)
   );

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         st         <= ST_IDLE;
         bitcnt     <= '0;
         sh         <= '0;
         tx         <= '0;
         ahi        <= '0;
         addr_ptr   <= '0;
         in_ack     <= 1'b0;
         rd_dir     <= 1'b0;
         more       <= 1'b0;
         wr_pending <= 1'b0;
         sda_oe_o   <= 1'b0;
      end else if (stop_det) begin
         st         <= ST_IDLE;
         in_ack     <= 1'b0;
         wr_pending <= 1'b0;
         sda_oe_o   <= 1'b0;
      end else if (start_det) begin
         st         <= ST_DEV;
         bitcnt     <= '0;
         in_ack     <= 1'b0;
         wr_pending <= 1'b0;
         sda_oe_o   <= 1'b0;
      end else if (st != ST_IDLE) begin
         if (scl_rise) begin
            if (in_ack) more <= !sda_q;
            else begin
               bitcnt <= bitcnt + 4'd1;
               if (st != ST_RDAT) sh <= {sh[6:0], sda_q};
            end
         end else if (scl_fall) begin
            if (in_ack) begin
               in_ack   <= 1'b0;
               sda_oe_o <= 1'b0;
               if ((st == ST_DEV && rd_dir) || (st == ST_RDAT && more)) begin
                  st       <= ST_RDAT;
                  bitcnt   <= '0;
                  tx       <= rd_data[6:0];
                  sda_oe_o <= !rd_data[7];
                  addr_ptr <= addr_inc;
               end else begin
                  case (st)
                     ST_DEV:  st <= ST_AHI;
                     ST_AHI:  st <= ST_ALO;
                     ST_ALO:  st <= ST_WDAT;
                     ST_RDAT: st <= ST_IDLE;
                     default: ;
                  endcase
               end
            end else if (byte_done) begin
               bitcnt <= '0;
               case (st)
                  ST_DEV:
                     if (sh[7:1] == {DEV_TYPE, chip_sel_i} && !busy) begin
                        sda_oe_o <= 1'b1;
                        in_ack   <= 1'b1;
                        rd_dir   <= sh[0];
                     end else st <= ST_IDLE;
                  ST_AHI: begin
                     ahi      <= sh[ADDR_W-9:0];
                     sda_oe_o <= 1'b1;
                     in_ack   <= 1'b1;
                  end
                  ST_ALO: begin
                     addr_ptr <= {ahi, sh};
                     sda_oe_o <= 1'b1;
                     in_ack   <= 1'b1;
                  end
                  ST_WDAT:
                     if (wp_i) st <= ST_IDLE;
                     else begin
                        addr_ptr   <= page_inc;
                        wr_pending <= 1'b1;
                        sda_oe_o   <= 1'b1;
                        in_ack     <= 1'b1;
                     end
                  ST_RDAT: begin
                     sda_oe_o <= 1'b0;
                     in_ack   <= 1'b1;
                  end
                  default: ;
               endcase
            end else if (st == ST_RDAT && bitcnt != 4'd0) begin
               sda_oe_o <= !tx[6];
               tx       <= {tx[5:0], 1'b0};
            end
         end
      end
endmodule

// File: rtl/i2c_ee_chk.sv
module i2c_ee_chk
   import i2c_ee_pkg::*;
#(
   parameter int ADDR_W    = 10,
   parameter int PAGE_BITS = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_q,
   input logic              stop_det,
   input logic              sda_oe_o,
   input logic              busy,
   input logic              in_ack,
   input ee_state_t         st,
   input logic [ADDR_W-1:0] addr_ptr
);
   AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe_o != $past(sda_oe_o)) |-> !scl_q); // R9

   AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && st == ST_DEV) |-> !in_ack); // R5

   AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WDAT && $past(st) == ST_WDAT) |->
         addr_ptr[ADDR_W-1:PAGE_BITS] == $past(addr_ptr[ADDR_W-1:PAGE_BITS])); // R3

   AST_PROG_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_det)); // R4
endmodule

bind i2c_eeprom_target i2c_ee_chk #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) chk_i (
   .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .stop_det(stop_det),
   .sda_oe_o(sda_oe_o), .busy(busy), .in_ack(in_ack), .st(st), .addr_ptr(addr_ptr)
);

// File: tb/i2c_eeprom_target_tb_top.sv
module i2c_eeprom_target_tb_top;
   localparam int Q = 5;
   logic clk = 1'b0, rst_n = 1'b0;
   logic m_scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
   logic sda_oe, sda_line;
   logic [2:0] csel = 3'b101;
   int checks = 0, errors = 0, oe_bad = 0;
   int exp_q[$], obs_q[$];
   string tag_q[$];
   localparam logic [7:0] DEV_W = 8'b1010_1010, DEV_R = 8'b1010_1011;

   always #10 clk = ~clk;
   assign sda_line = m_sda & ~sda_oe;

   i2c_eeprom_target #(.WR_CYCLE_CLKS(600)) dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
      .chip_sel_i(csel), .wp_i(wp), .sda_oe_o(sda_oe)
   );

   logic oe_prev = 1'b0;
   always @(posedge clk) begin
      if (sda_oe != oe_prev && m_scl) oe_bad++;
      oe_prev <= sda_oe;
   end

   task automatic expect_item(string tag, int v);
      tag_q.push_back(tag);
      exp_q.push_back(v);
   endtask

   initial forever begin
      @(posedge clk);
      while (obs_q.size() > 0 && exp_q.size() > 0) begin
         automatic int e = exp_q.pop_front();
         automatic int o = obs_q.pop_front();
         automatic string t = tag_q.pop_front();
         checks++;
         if (e != o) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", t, o, e);
         end
      end
   end

   task automatic chk(string tag, int exp_v, int act_v);
      expect_item(tag, exp_v);
      obs_q.push_back(act_v);
   endtask

   task automatic qw;
      repeat (Q) @(negedge clk);
   endtask

   task automatic bit_io(input logic b, output logic r);
      m_sda = b; qw; m_scl = 1'b1; qw; r = sda_line; qw; m_scl = 1'b0; qw;
   endtask

   task automatic i2c_start;
      m_sda = 1'b1; qw; m_scl = 1'b1; qw; m_sda = 1'b0; qw; m_scl = 1'b0; qw;
   endtask

   task automatic i2c_stop;
      m_sda = 1'b0; qw; m_scl = 1'b1; qw; m_sda = 1'b1; qw;
   endtask

   task automatic wr_byte(input logic [7:0] b, output logic ack);
      logic r;
      for (int i = 7; i >= 0; i--) bit_io(b[i], r);
      bit_io(1'b1, r);
      ack = !r;
   endtask

   task automatic rd_byte(input logic mack, output logic [7:0] d);
      logic r;
      for (int i = 0; i < 8; i++) begin bit_io(1'b1, r); d = {d[6:0], r}; end
      bit_io(!mack, r);
   endtask

   task automatic ack_chk(string tag, logic [7:0] b, logic exp_ack);
      logic a;
      wr_byte(b, a);
      chk(tag, int'(exp_ack), int'(a));
   endtask

   task automatic rd_chk(string tag, logic mack, logic [7:0] exp_v);
      logic [7:0] d;
      rd_byte(mack, d);
      chk(tag, int'(exp_v), int'(d));
   endtask

   task automatic set_addr(string tag, logic [15:0] a);
      i2c_start;
      ack_chk({tag, " dev"}, DEV_W, 1'b1);
      ack_chk({tag, " addr hi"}, a[15:8], 1'b1);
      ack_chk({tag, " addr lo"}, a[7:0], 1'b1);
   endtask

   task automatic rand_rd(string tag, logic [15:0] a);
      set_addr(tag, a);
      i2c_start;
      ack_chk({tag, " read dev"}, DEV_R, 1'b1);
   endtask

   task automatic poll(string tag, logic exp_busy);
      logic a;
      for (int i = 0; i < 20; i++) begin
         i2c_start; wr_byte(DEV_W, a); i2c_stop;
         if (i == 0) chk({tag, " first poll"}, int'(!exp_busy), int'(a));
         if (a) break;
      end
      chk({tag, " ready"}, 1, int'(a));
   endtask

   task automatic byte_write(logic [15:0] a, logic [7:0] d);
      set_addr("R2", a);
      ack_chk("R2 data", d, 1'b1);
      i2c_stop;
      poll("R5", 1'b1);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      chk("R9 reset oe", 0, int'(sda_oe));
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      i2c_start;                       // R1 foreign address
      ack_chk("R1 foreign", 8'b1010_0110, 1'b0);
      i2c_stop;
      byte_write(16'hC123, 8'h5A);     // upper bits don't care
      byte_write(16'h0200, 8'h11);
      byte_write(16'h03FF, 8'hE7);
      byte_write(16'h0000, 8'h3C);
      rand_rd("R2", 16'h0123);
      rd_chk("R2 readback", 1'b0, 8'h5A);
      i2c_stop;
      set_addr("R4", 16'h0200);        // R4: cut by repeated start
      ack_chk("R4 data", 8'h77, 1'b1);
      rand_rd("R4", 16'h0200);
      rd_chk("R4 unchanged", 1'b0, 8'h11);
      i2c_stop;
      poll("R4 no cycle", 1'b0);
      set_addr("R3", 16'h0140);        // 66 bytes: wraps onto offsets 0,1
      for (int i = 0; i < 66; i++) ack_chk("R3 page data", 8'(i + 16), 1'b1);
      i2c_stop;
      poll("R5 page", 1'b1);
      set_addr("R3", 16'h017F);
      ack_chk("R3 data", 8'hAA, 1'b1);
      ack_chk("R3 data", 8'hBB, 1'b1);
      i2c_stop;
      poll("R5", 1'b1);
      rand_rd("R3", 16'h017F);
      rd_chk("R3 page end", 1'b0, 8'hAA);
      i2c_stop;
      rand_rd("R8", 16'h0140);
      rd_chk("R3 in-page wrap", 1'b1, 8'hBB);
      rd_chk("R3 overwrite", 1'b1, 8'h51);
      rd_chk("R8 sequential", 1'b0, 8'h12);
      chk("R8 release after nack", 0, int'(sda_oe));
      i2c_stop;
      i2c_start;
      ack_chk("R7 read dev", DEV_R, 1'b1);
      rd_chk("R7 current", 1'b0, 8'h13);
      i2c_stop;
      rand_rd("R8", 16'h03FF);
      rd_chk("R8 top", 1'b1, 8'hE7);
      rd_chk("R8 wrap", 1'b0, 8'h3C);
      i2c_stop;
      rand_rd("R7", 16'h03FF);
      rd_chk("R7 top", 1'b0, 8'hE7);
      i2c_stop;
      i2c_start;
      ack_chk("R7 read dev", DEV_R, 1'b1);
      rd_chk("R7 wrap", 1'b0, 8'h3C);
      i2c_stop;
      wp = 1'b1;
      set_addr("R6", 16'h0123);
      ack_chk("R6 data refused", 8'hFF, 1'b0);
      i2c_stop;
      poll("R6 no cycle", 1'b0);
      wp = 1'b0;
      rand_rd("R6", 16'h0123);
      rd_chk("R6 unchanged", 1'b0, 8'h5A);
      i2c_stop;
      chk("R9 oe change while scl high", 0, oe_bad);
      wait (obs_q.size() == 0);
      repeat (2) @(posedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule